// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block collects eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt line toward the processor. When the processor acknowledges, the block answers with an 8-bit vector. The vector is a software-programmed base plus the number of the winning line. The block records the winning line as in service until software retires it. If auto-retire mode is programmed, the block never holds the line in service at all.

Software reaches the block through two byte-wide addresses. The command address accepts the start of an initialization sequence, end-of-interrupt commands and the choice of which status register later command reads return. The data address receives the remaining initialization bytes and, once initialization is complete, the mask. Requests are captured on rising edges. A request that disappears before the acknowledge produces the lowest-priority vector without marking anything in service. A parameter chooses master or slave role, and the role decides how the cascade byte is kept.

Top module: `vic8_ctrl`

## Requirements
- R1: After reset the in-service register and the mask are zero, command reads return the request register, the interrupt output is low, auto-retire is off and the vector base equals the RESET_BASE parameter.
- R2: A command write with bit 4 set starts initialization. Bit 0 of that byte requests a mode byte and bit 1 skips the cascade byte. The following data writes are taken in order as vector base, cascade byte (unless skipped) and mode byte (if requested). Only after these does a data write load the mask.
- R3: An acknowledge (ack high for one cycle) that grants line n makes vec_out equal base+n (modulo 256) from the next cycle.
- R4: int_out is high exactly when some request-register bit that is not masked has a lower line number than the lowest-numbered in-service bit, or no bit is in service. Line 0 has the highest priority.
- R5: An acknowledge with auto-retire off moves the granted line's bit from the request register into the in-service register.
- R6: An acknowledge with no line eligible returns base+7 and leaves the in-service register unchanged. A line is eligible when it is pending, unmasked, still driven high and ranked above every in-service bit.
- R7: With mode-byte bit 1 set (auto-retire), an acknowledge returns the vector but sets no in-service bit.
- R8: A command write of 0x60 OR k (k = 0..7) clears in-service bit k only.
- R9: A command write of 0x0A selects the request register and 0x0B selects the in-service register for command reads. The choice persists until changed. A read strobe puts the value on rdata in the next cycle.
- R10: A data-address read returns the mask. Mask bit k set blocks line k, so 0xFF keeps int_out low.
- R11: A request bit is set only by a rising edge on its input and is dropped when the input falls. An input held high after its acknowledge raises no new request.
- R12: Starting initialization clears the in-service register and the mask, turns auto-retire off and resets the read selection to the request register.
- R13: A master keeps the whole cascade byte on casc_out. A slave keeps only bits 2:0, which hold its identity, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | 0 selects command address, 1 selects data address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| req_in | input | 8 | Interrupt request lines, line 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| casc_out | output | 8 | Stored cascade configuration |

## Verification
The bench builds two copies that share all stimulus. One uses the default master role and the other sets IS_SLAVE to 1. The same cascade byte therefore shows up in full on one copy and cut down to an identity on the other. Both keep RESET_BASE at zero, so the reset-state vector base is known before any initialization. With these values, normal and auto-retire modes, the sequence that skips the cascade byte, spurious acknowledges and the nesting of in-service levels are all reachable.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_W = 8;
    localparam int LVL_W = $clog2(VIC_W);

    typedef enum logic [1:0] {
        PH_READY,
        PH_BASE,
        PH_CASC,
        PH_MODE
    } vic_phase_e;

    typedef struct packed {
        vic_phase_e         phase;
        logic               want_mode;
        logic               no_casc;
        logic               aeoi;
        logic               sel_isr;
        logic [VIC_W-1:0]   base;
        logic [VIC_W-1:0]   casc;
        logic [VIC_W-1:0]   mask;
        logic [VIC_W-1:0]   isr;
        logic [VIC_W-1:0]   irr;
        logic [VIC_W-1:0]   req_prev;
        logic [VIC_W-1:0]   rdata;
        logic [VIC_W-1:0]   vec;
    } vic_state_t;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_req_edge.sv
module vic_req_edge #(
    parameter int W = 8
) (
    input  logic [W-1:0] req_in,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] irr_cur,
    output logic [W-1:0] irr_next
);
    // A bit is raised on a rising edge and dropped once its input falls.
    always_comb begin
        irr_next = (irr_cur | (req_in & ~prev)) & req_in;
    end
endmodule

// File: rtl/vic8_ctrl.sv
module vic8_ctrl
    import vic_pkg::*;
#(
    parameter bit         IS_SLAVE   = 1'b0,
    parameter logic [7:0] RESET_BASE = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] req_in,
    output logic       int_out,
    input  logic       ack,
    output logic [7:0] vec_out,
    output logic [7:0] casc_out
);
    localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(VIC_W - 1);
    localparam logic [2:0]       SEOI_OP  = 3'b011;

    vic_state_t s_q, s_d;

    logic [VIC_W-1:0] irr_next, elig, pend;
    logic             g_found, p_found, s_found, grant_ok;
    logic [LVL_W-1:0] g_idx, p_idx, s_idx;

    // Signals brought out for the bound checker.
    logic [VIC_W-1:0] irr_w, isr_w, mask_w;
    logic             aeoi_w;

    vic_req_edge #(.W(VIC_W)) u_edge (
        .req_in   (req_in),
        .prev     (s_q.req_prev),
        .irr_cur  (s_q.irr),
        .irr_next (irr_next)
    );

    assign elig = s_q.irr & req_in & ~s_q.mask;
    assign pend = s_q.irr & ~s_q.mask;

    vic_prio_enc #(.W(VIC_W)) u_grant (.vec(elig),    .found(g_found), .idx(g_idx));
    vic_prio_enc #(.W(VIC_W)) u_pend  (.vec(pend),    .found(p_found), .idx(p_idx));
    vic_prio_enc #(.W(VIC_W)) u_serv  (.vec(s_q.isr), .found(s_found), .idx(s_idx));

    assign grant_ok = g_found && (!s_found || (g_idx < s_idx));
    assign int_out  = p_found && (!s_found || (p_idx < s_idx));

    always_comb begin
        s_d          = s_q;
        s_d.req_prev = req_in;
        s_d.irr      = irr_next;

        // Acknowledge: grant or report spurious level.
        if (ack) begin
            if (grant_ok) begin
                s_d.irr[g_idx] = 1'b0;
                if (!s_q.aeoi) begin
                    s_d.isr[g_idx] = 1'b1;
                end
                s_d.vec = s_q.base + VIC_W'(g_idx);
            end else begin
                s_d.vec = s_q.base + VIC_W'(SPUR_LVL);
            end
        end

        // Register reads return pre-update contents.
        if (rd_en) begin
            if (addr) begin
                s_d.rdata = s_q.mask;
            end else begin
                s_d.rdata = s_q.sel_isr ? s_q.isr : s_q.irr;
            end
        end

        if (wr_en) begin
            if (!addr) begin
                if (wdata[4]) begin
                    s_d.phase     = PH_BASE;
                    s_d.want_mode = wdata[0];
                    s_d.no_casc   = wdata[1];
                    s_d.isr       = '0;
                    s_d.mask      = '0;
                    s_d.sel_isr   = 1'b0;
                    s_d.aeoi      = 1'b0;
                end else if (wdata[3]) begin
                    if (wdata[1]) begin
                        s_d.sel_isr = wdata[0];
                    end
                end else if (wdata[7:5] == SEOI_OP) begin
                    s_d.isr[wdata[2:0]] = 1'b0;
                end
            end else begin
                unique case (s_q.phase)
                    PH_BASE: begin
                        s_d.base = wdata;
                        if (!s_q.no_casc) begin
                            s_d.phase = PH_CASC;
                        end else begin
                            s_d.phase = s_q.want_mode ? PH_MODE : PH_READY;
                        end
                    end
                    PH_CASC: begin
                        if (IS_SLAVE) begin
                            s_d.casc = {5'b0, wdata[2:0]};
                        end else begin
                            s_d.casc = wdata;
                        end
                        s_d.phase = s_q.want_mode ? PH_MODE : PH_READY;
                    end
                    PH_MODE: begin
                        s_d.aeoi  = wdata[1];
                        s_d.phase = PH_READY;
                    end
                    default: begin
                        s_d.mask = wdata;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_READY;
            s_q.base  <= RESET_BASE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.rdata;
    assign vec_out  = s_q.vec;
    assign casc_out = s_q.casc;
    assign irr_w    = s_q.irr;
    assign isr_w    = s_q.isr;
    assign mask_w   = s_q.mask;
    assign aeoi_w   = s_q.aeoi;
endmodule

// File: rtl/vic8_ctrl_chk.sv
module vic8_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       addr,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] req_in,
    input logic       ack,
    input logic       int_out,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [7:0] mask,
    input logic       aeoi
);
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (isr == 8'h00 && mask == 8'h00 && !int_out));

    p_int_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != 8'h00));

    p_ack_sets_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi && !wr_en && ((irr & ~mask & ~req_in) == 8'h00))
        |=> ($countones(isr) == $past($countones(isr)) + 1));

    p_spurious_no_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !wr_en) |=> $stable(isr));

    p_aeoi_no_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !wr_en) |=> $stable(isr));

    p_seoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:5] == 3'b011 && wdata[4:3] == 2'b00 && !ack)
        |=> (isr == ($past(isr) & ~(8'h01 << $past(wdata[2:0])))));

    p_full_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'hFF) |-> !int_out);
endmodule

bind vic8_ctrl vic8_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .req_in  (req_in),
    .ack     (ack),
    .int_out (int_out),
    .irr     (irr_w),
    .isr     (isr_w),
    .mask    (mask_w),
    .aeoi    (aeoi_w)
);

// File: tb/vic8_ctrl_bench.sv
module vic8_ctrl_bench;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
    logic [7:0] wdata = 8'h00, req_in = 8'h00;
    logic [7:0] rdata, vec_out, casc_out, rdata_s, vec_s, casc_s;
    logic       int_out, int_s;

    int checks = 0;
    int errors = 0;

    // Bench model of the programmer-visible state.
    logic [7:0] m_irr, m_isr, m_mask, m_base, m_casc, m_prev;
    logic       m_aeoi, m_sel, m_need, m_single;
    int         m_phase;

    always #(CLK_P / 2) clk = ~clk;

    vic8_ctrl u_vic8_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .req_in(req_in), .int_out(int_out),
        .ack(ack), .vec_out(vec_out), .casc_out(casc_out)
    );

    vic8_ctrl #(.IS_SLAVE(1'b1)) u_vic8_ctrl_slv (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata_s), .req_in(req_in), .int_out(int_s),
        .ack(ack), .vec_out(vec_s), .casc_out(casc_s)
    );

    function automatic int top_lvl(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic model_int();
        int p = top_lvl(m_irr & ~m_mask);
        int s = top_lvl(m_isr);
        return (p < 8) && (p < s);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; model advances and outputs are compared.
    task automatic step(input logic [7:0] rq, input logic ak, input logic wr,
                        input logic a, input logic [7:0] wd, input logic rd);
        logic [7:0] elig, ev, er;
        int g, s;
        logic gok;
        req_in = rq; ack = ak; wr_en = wr; addr = a; wdata = wd; rd_en = rd;
        elig = m_irr & rq & ~m_mask;
        g = top_lvl(elig);
        s = top_lvl(m_isr);
        gok = (g < 8) && (g < s);
        ev = gok ? m_base + 8'(g) : m_base + 8'd7;
        er = a ? m_mask : (m_sel ? m_isr : m_irr);
        m_irr = (m_irr | (rq & ~m_prev)) & rq;
        m_prev = rq;
        if (ak && gok) begin
            m_irr[g] = 1'b0;
            if (!m_aeoi) m_isr[g] = 1'b1;
        end
        if (wr) begin
            if (!a) begin
                if (wd[4]) begin
                    m_phase = 1; m_need = wd[0]; m_single = wd[1];
                    m_isr = 0; m_mask = 0; m_sel = 0; m_aeoi = 0;
                end else if (wd[3]) begin
                    if (wd[1]) m_sel = wd[0];
                end else if (wd[7:5] == 3'b011) begin
                    m_isr[wd[2:0]] = 1'b0;
                end
            end else begin
                case (m_phase)
                    1: begin m_base = wd; m_phase = m_single ? (m_need ? 3 : 0) : 2; end
                    2: begin m_casc = wd; m_phase = m_need ? 3 : 0; end
                    3: begin m_aeoi = wd[1]; m_phase = 0; end
                    default: m_mask = wd;
                endcase
            end
        end
        @(negedge clk);
        if (ak) chk(gok ? "R3" : "R6", vec_out, ev);
        if (rd) chk(a ? "R10" : "R9", rdata, er);
        chk("R4", {7'b0, int_out}, {7'b0, model_int()});
    endtask

    task automatic idle(input logic [7:0] rq);
        step(rq, 0, 0, 0, 8'h00, 0);
    endtask

    task automatic wcmd(input logic [7:0] rq, input logic [7:0] d);
        step(rq, 0, 1, 0, d, 0);
    endtask

    task automatic wdat(input logic [7:0] rq, input logic [7:0] d);
        step(rq, 0, 1, 1, d, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rq;
        m_irr = 0; m_isr = 0; m_mask = 0; m_base = 0; m_casc = 0; m_prev = 0;
        m_aeoi = 0; m_sel = 0; m_need = 0; m_single = 0; m_phase = 0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", {7'b0, int_out}, 8'h00);
        step(8'h00, 0, 0, 1, 8'h00, 1);
        chk("R1", rdata, 8'h00);
        wcmd(8'h00, 8'h0B);
        step(8'h00, 0, 0, 0, 8'h00, 1);
        chk("R1", rdata, 8'h00);
        wcmd(8'h00, 8'h0A);

        // R2, R13: full init, master/slave cascade storage
        wcmd(8'h00, 8'h11);
        wdat(8'h00, 8'h20);
        wdat(8'h00, 8'h0A);
        wdat(8'h00, 8'h00);
        chk("R13", casc_out, 8'h0A);
        chk("R13", casc_s, 8'h02);
        wdat(8'h00, 8'h81);
        step(8'h00, 0, 0, 1, 8'h00, 1);
        chk("R2", rdata, 8'h81);
        wdat(8'h00, 8'h00);

        // R5, R3, R4: nesting
        idle(8'h28);
        step(8'h28, 1, 0, 0, 8'h00, 0);
        chk("R3", vec_out, 8'h23);
        chk("R4", {7'b0, int_out}, 8'h00);
        idle(8'h2A);
        chk("R4", {7'b0, int_out}, 8'h01);
        step(8'h2A, 1, 0, 0, 8'h00, 0);
        chk("R3", vec_out, 8'h21);
        wcmd(8'h2A, 8'h0B);
        step(8'h2A, 0, 0, 0, 8'h00, 1);
        chk("R5", rdata, 8'h0A);
        step(8'h2A, 0, 0, 0, 8'h00, 1);
        chk("R9", rdata, 8'h0A);

        // R8: specific retire
        wcmd(8'h2A, 8'h61);
        step(8'h2A, 0, 0, 0, 8'h00, 1);
        chk("R8", rdata, 8'h08);
        wcmd(8'h2A, 8'h63);
        chk("R4", {7'b0, int_out}, 8'h01);

        // R11: held input does not re-request
        step(8'h2A, 1, 0, 0, 8'h00, 0);
        chk("R3", vec_out, 8'h25);
        wcmd(8'h2A, 8'h65);
        idle(8'h2A);
        chk("R11", {7'b0, int_out}, 8'h00);

        // R6: request vanishes before acknowledge
        idle(8'h00);
        idle(8'h40);
        step(8'h00, 1, 0, 0, 8'h00, 0);
        chk("R6", vec_out, 8'h27);
        step(8'h00, 0, 0, 0, 8'h00, 1);
        chk("R6", rdata, 8'h00);

        // R10: full mask
        wdat(8'h00, 8'hFF);
        idle(8'h5F);
        chk("R10", {7'b0, int_out}, 8'h00);
        step(8'h5F, 0, 0, 1, 8'h00, 1);
        chk("R10", rdata, 8'hFF);
        wdat(8'h5F, 8'h00);
        step(8'h5F, 1, 0, 0, 8'h00, 0);

        // R12: init start clears service state
        wcmd(8'h5F, 8'h11);
        step(8'h5F, 0, 0, 1, 8'h00, 1);
        chk("R12", rdata, 8'h00);
        wcmd(8'h5F, 8'h0B);
        step(8'h5F, 0, 0, 0, 8'h00, 1);
        chk("R12", rdata, 8'h00);

        // R7: auto-retire mode
        wdat(8'h00, 8'h40);
        wdat(8'h00, 8'h0A);
        wdat(8'h00, 8'h02);
        idle(8'h10);
        step(8'h10, 1, 0, 0, 8'h00, 0);
        chk("R7", vec_out, 8'h44);
        wcmd(8'h10, 8'h0B);
        step(8'h10, 0, 0, 0, 8'h00, 1);
        chk("R7", rdata, 8'h00);

        // R2: cascade byte skipped
        wcmd(8'h00, 8'h13);
        wdat(8'h00, 8'h50);
        wdat(8'h00, 8'h00);
        wdat(8'h00, 8'h3C);
        step(8'h00, 0, 0, 1, 8'h00, 1);
        chk("R2", rdata, 8'h3C);
        chk("R13", casc_out, 8'h0A);
        wdat(8'h00, 8'h00);

        // Random phase
        rq = 8'h00;
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic ak;
            if ($urandom % 3 == 0) rq = rq ^ (8'h01 << ($urandom % 8));
            ak = ($urandom % 5 == 0);
            op = $urandom % 10;
            case (op)
                3: step(rq, ak, 1, 0, 8'h60 | 8'($urandom % 8), 0);
                4: step(rq, ak, 1, 0, ($urandom % 2) ? 8'h0B : 8'h0A, 0);
                5: step(rq, ak, 1, 1, 8'($urandom) & 8'($urandom), 0);
                6: step(rq, ak, 0, 0, 8'h00, 1);
                7: step(rq, ak, 0, 1, 8'h00, 1);
                default: step(rq, ak, 0, 0, 8'h00, 0);
            endcase
        end
        idle(8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule